// File: doc/BRIEF.md
# GPIO Bank with Atomic Set/Clear Control

A bank of 32 general-purpose pins sitting on a simple 32-bit memory-mapped register bus. Each pin has an output latch and a direction bit. Software changes either one only through dedicated registers: a 1 in a written bit sets or clears that one pin, and a 0 leaves it alone. No read-modify-write sequence is needed, so two software agents can drive different pins without sharing a lock.

The bank drives an output value and an output enable toward each pad. Pad input levels pass through a two-flop synchronizer before software can read them. The value register returns a mixed view: the output latch for pins that drive, and the synchronized pad level for pins that listen.

The bus has an address, a write strobe and write data. A write takes effect at the clock edge that samples it. The read data for the address presented is registered at that same edge and is valid in the following cycle. Interrupt detection, pad electrical behaviour, pull resistors and pin muxing are left to other blocks.

Top module: `gpio_bank`

## Requirements
- R1: After reset every pin is an input (pad_oe_o all 0), every output latch bit is 0, and rdata_o is 0.
- R2: The register is chosen by the word index addr_i[7:2]. addr_i[1:0] is ignored. The word offsets are: 0x00 direction, 0x04 make-output, 0x08 make-input, 0x0C value, 0x10 output-set, 0x14 output-clear.
- R3: A write to 0x04 turns each pin whose data bit is 1 into an output. Pins whose bit is 0 keep their direction.
- R4: A write to 0x08 turns each pin whose data bit is 1 into an input. Pins whose bit is 0 keep their direction.
- R5: A write to 0x10 sets the output latch of each pin whose data bit is 1. The other latch bits are unchanged.
- R6: A write to 0x14 clears the output latch of each pin whose data bit is 1. The other latch bits are unchanged.
- R7: A read of 0x00 returns the direction bits, where 1 means input (output enable low). Writes to 0x00 have no effect.
- R8: A read of 0x0C returns the output latch bit for output pins and the synchronized pad level for input pins. Writes to 0x0C have no effect.
- R9: A pad level change made before a clock edge is not seen by reads presented at that edge or at the next one. It is seen by a read presented at the edge after those.
- R10: Reads of 0x04, 0x08, 0x10 and 0x14 return 0.
- R11: Reads of any unmapped word return 0. Writes to an unmapped word change neither the direction nor the output latch.
- R12: pad_out_o always shows the output latch, including for input pins. pad_oe_o is the inverse of the direction bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered, for the address presented in the previous cycle |
| pad_in_i | input | 32 | Pad input levels, asynchronous |
| pad_out_o | output | 32 | Output value toward the pads |
| pad_oe_o | output | 32 | Output enable per pad, 1 = drive |

## Verification
A wrong direction bit shows on pad_oe_o in the cycle after the write that caused it. It also changes which source the value register returns, so both the direction read and the value read disagree at once. A corrupted output latch bit shows on pad_out_o straight away, even for input pins, so the bench's model catches latch errors before the pin is ever made an output. A synchronizer with too few or too many stages moves by one read the point where a pad change first becomes visible, and the directed latency check pins that point exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned WORD_DIR     = 0;
  localparam int unsigned WORD_DIR_OUT = 1;
  localparam int unsigned WORD_DIR_IN  = 2;
  localparam int unsigned WORD_VAL     = 3;
  localparam int unsigned WORD_OUT_SET = 4;
  localparam int unsigned WORD_OUT_CLR = 5;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W   = 32,
  parameter int unsigned IDX = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [IDX-1:0] idx_i,
  input  logic           we_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   dir_o,
  output logic [W-1:0]   out_o
);
  logic [W-1:0] dir_q, out_q, dir_d, out_d;

  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    if (we_i) begin
      unique case (int'(idx_i))
        WORD_DIR_OUT: dir_d = dir_q & ~wdata_i;
        WORD_DIR_IN:  dir_d = dir_q | wdata_i;
        WORD_OUT_SET: out_d = out_q | wdata_i;
        WORD_OUT_CLR: out_d = out_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      dir_q <= dir_d;
      out_q <= out_d;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;

  AST_SET_NEVER_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) == WORD_OUT_SET) |=> ((out_q & $past(out_q)) == $past(out_q))); // R5
  AST_CLR_NEVER_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) == WORD_OUT_CLR) |=> ((out_q & ~$past(out_q)) == '0)); // R6
  AST_DIR_OUT_ONLY_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) == WORD_DIR_OUT) |=> ((dir_q & ~$past(dir_q)) == '0)); // R3
  AST_DIR_IN_ONLY_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) == WORD_DIR_IN) |=> ((dir_q & $past(dir_q)) == $past(dir_q))); // R4
  AST_OTHER_WRITE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && int'(idx_i) != WORD_DIR_OUT && int'(idx_i) != WORD_DIR_IN &&
     int'(idx_i) != WORD_OUT_SET && int'(idx_i) != WORD_OUT_CLR)
    |=> ($stable(dir_q) && $stable(out_q))); // R11
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  pad_in_i,
  output logic [W-1:0]  pad_out_o,
  output logic [W-1:0]  pad_oe_o
);
  localparam int unsigned IDX = AW - 2;

  logic [IDX-1:0] idx;
  logic [W-1:0]   dir, out_lat, pad_sync, rdata_d, rdata_q;

  assign idx = addr_i[AW-1:2];

  gpio_bank_regs #(.W(W), .IDX(IDX)) u_regs (
    .clk_i, .rst_ni, .idx_i(idx), .we_i, .wdata_i,
    .dir_o(dir), .out_o(out_lat)
  );

  gpio_bank_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_in_i), .q_o(pad_sync)
  );

  always_comb begin
    unique case (int'(idx))
      WORD_DIR: rdata_d = dir;
      WORD_VAL: rdata_d = (out_lat & ~dir) | (pad_sync & dir);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else rdata_q <= rdata_d;
  end

  assign rdata_o   = rdata_q;
  assign pad_out_o = out_lat;
  assign pad_oe_o  = ~dir;

  AST_SETCLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx) == WORD_DIR_OUT || int'(idx) == WORD_DIR_IN ||
     int'(idx) == WORD_OUT_SET || int'(idx) == WORD_OUT_CLR) |=> (rdata_o == '0)); // R10
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx) > WORD_OUT_CLR) |=> (rdata_o == '0)); // R11
  AST_OUTPUT_PIN_READS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx) == WORD_VAL) |=> ((rdata_o & $past(pad_oe_o)) == ($past(pad_out_o) & $past(pad_oe_o)))); // R8
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int W = 32;
  localparam logic [7:0] A_DIR = 8'h00, A_DOUT = 8'h04, A_DIN = 8'h08,
                         A_VAL = 8'h0C, A_SET = 8'h10, A_CLR = 8'h14, A_UNM = 8'h18;

  logic clk_i = 0, rst_ni = 0, we_i = 0;
  logic [7:0] addr_i = A_UNM;
  logic [W-1:0] wdata_i = '0, pad_in_i = '0;
  logic [W-1:0] rdata_o, pad_out_o, pad_oe_o;

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] m_dir = '1, m_out = '0;

  gpio_bank dut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [W-1:0] exp_val(logic [W-1:0] d, logic [W-1:0] o, logic [W-1:0] p);
    return (o & ~d) | (p & d);
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [W-1:0] d);
    addr_i = a; wdata_i = d; we_i = 1;
    @(negedge clk_i);
    we_i = 0; addr_i = A_UNM;
    case (a[7:2])
      6'd1: m_dir &= ~d;
      6'd2: m_dir |= d;
      6'd4: m_out |= d;
      6'd5: m_out &= ~d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [7:0] a, output logic [W-1:0] d);
    addr_i = a; we_i = 0;
    @(negedge clk_i);
    d = rdata_o;
    addr_i = A_UNM;
  endtask

  task automatic set_pad(logic [W-1:0] p);
    pad_in_i = p;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic check_all(string tag);
    logic [W-1:0] r;
    rd(A_DIR, r);  chk({tag, " R7 dir"}, r, m_dir);
    rd(A_VAL, r);  chk({tag, " R8 val"}, r, exp_val(m_dir, m_out, pad_in_i));
    chk({tag, " R12 oe"}, pad_oe_o, ~m_dir);
    chk({tag, " R12 out"}, pad_out_o, m_out);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog R1 act=%h exp=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R1 oe", pad_oe_o, '0);
    chk("R1 out", pad_out_o, '0);
    chk("R1 rdata", rdata_o, '0);
    rst_ni = 1;
    @(negedge clk_i);
    check_all("R1");

    // R5/R6 latch writes while pins are inputs, then drive them
    wr(A_SET, 32'hF0F0_00FF); check_all("R5 set-as-input");
    wr(A_CLR, 32'h0000_000F); check_all("R6 clr");
    wr(A_DOUT, 32'h0000_FFFF); check_all("R3 dout");
    wr(A_DIN, 32'h0000_0F00); check_all("R4 din");
    wr(A_DIR, 32'h0000_0000); check_all("R7 dir write ignored");
    wr(A_VAL, 32'hFFFF_FFFF); check_all("R8 val write ignored");
    wr(A_UNM, 32'hFFFF_FFFF); check_all("R11 unmapped write");
    wr(8'hFC, 32'h0000_0000); check_all("R11 high unmapped write");
    wr(8'h13, 32'h0001_0000); check_all("R2 low addr bits ignored");
    rd(8'h0E, r); chk("R2 val alias", r, exp_val(m_dir, m_out, pad_in_i));

    foreach (r[i]) ;
    rd(A_DOUT, r); chk("R10 dout read", r, '0);
    rd(A_DIN, r);  chk("R10 din read", r, '0);
    rd(A_SET, r);  chk("R10 set read", r, '0);
    rd(A_CLR, r);  chk("R10 clr read", r, '0);
    rd(A_UNM, r);  chk("R11 unmapped read", r, '0);
    rd(8'hFC, r);  chk("R11 top unmapped read", r, '0);

    // R9 latency: all inputs, pad toggles
    wr(A_DIN, '1);
    set_pad(32'h0000_0000);
    pad_in_i = 32'hA5A5_5A5A;
    rd(A_VAL, r); chk("R9 first read old", r, 32'h0000_0000);
    rd(A_VAL, r); chk("R9 second read old", r, 32'h0000_0000);
    rd(A_VAL, r); chk("R9 third read new", r, 32'hA5A5_5A5A);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 8);
      logic [W-1:0] d = $urandom();
      case (op)
        0: wr(A_DOUT, d);
        1: wr(A_DIN, d);
        2: wr(A_SET, d);
        3: wr(A_CLR, d);
        4: wr(A_DIR, d);
        5: wr(A_VAL, d);
        6: wr(8'h18 + 8'($urandom_range(0, 57) * 4), d);
        default: set_pad(d);
      endcase
      check_all("R3/R4/R5/R6 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule